// File: doc/BRIEF.md
# Modulo-3 Up/Down Counter with Terminal Flag

This block is a synchronous counter that cycles through the values 0, 1 and 2. Each clock, an enable input decides whether it moves. A direction input decides whether the move is one step up or one step down. In both directions the count wraps, so 2 steps up to 0 and 0 steps down to 2. The present value is always driven on a 2-bit binary output.

A single-cycle flag marks the arrival at the end value for the current direction. That end value is 2 when counting up and 0 when counting down. The flag is a combinational (Mealy) function of the present value and the two control inputs. It is high during the cycle in which the qualifying step is enabled, one clock before the count output shows the new value. A parent block can use it as a carry or borrow into the next stage of a cascade.

An elaboration parameter picks how the state is held inside the block: a compact two-bit binary code or a three-bit one-hot code. The behaviour seen at the ports is the same for both. With the binary code, the unused code point returns to 0 on the next clock.

Top module: `mod3_updown_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count becomes 0 at that edge, and `termFlag` is low for as long as `rst` is high.
- R2: When `cntEn` is 0, the count keeps its value across the clock edge, whatever the value of `dirDown`.
- R3: When `cntEn` is 1 and `dirDown` is 0, the count goes up by one at the clock edge, and 2 wraps to 0.
- R4: When `cntEn` is 1 and `dirDown` is 1, the count goes down by one at the clock edge, and 0 wraps to 2.
- R5: `termFlag` is 1 in a cycle where `cntEn` is 1, `dirDown` is 0 and the count is 1, which is an up step that lands on 2.
- R6: `termFlag` is 1 in a cycle where `cntEn` is 1, `dirDown` is 1 and the count is 1, which is a down step that lands on 0.
- R7: `termFlag` is 0 in every other case. This covers all hold cycles and every step that starts from 0 or 2.
- R8: `count` is the value in plain binary (0 = 2'b00, 1 = 2'b01, 2 = 2'b10) and never reads 2'b11. The sequence of `count` and `termFlag` is the same whether `ONE_HOT` is 0 (two-bit binary state) or 1 (three-bit one-hot state).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cntEn | input | 1 | Step enable; when low the count holds |
| dirDown | input | 1 | Direction: 0 counts up, 1 counts down |
| count | output | 2 | Present value, 0 to 2, in binary |
| termFlag | output | 1 | Mealy flag: the enabled step lands on the terminal value for the current direction |

## Verification
The bench builds two instances side by side from the same stimulus: one with `ONE_HOT` at 0 (binary state register) and one with `ONE_HOT` at 1 (one-hot register). Every check is applied to both, so a fault in either next-state table or in either value decoder shows up as a mismatch against the bench's own model. With both variants present, the sweep reaches every (value, enable, direction) combination, including the two wrap steps and both flag cases, in both state representations.

// File: rtl/updn3_pkg.sv
package updn3_pkg;
  localparam int Modulus = 3;
  localparam int CountW  = 2;
  localparam int UpFrom  = Modulus - 2;
  localparam int DnFrom  = 1;

  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } stepStrb_t;
endpackage

// File: rtl/updn3_ctrl.sv
module updn3_ctrl
  import updn3_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cntEn,
  input  logic              dirDown,
  input  logic [CountW-1:0] countVal,
  output stepStrb_t         strb,
  output logic              termFlag
);
  logic upHit;
  logic dnHit;

  always_comb begin
    strb.stepUp   = cntEn & ~dirDown & ~rst;
    strb.stepDown = cntEn &  dirDown & ~rst;
    upHit    = strb.stepUp   && (countVal == CountW'(UpFrom));
    dnHit    = strb.stepDown && (countVal == CountW'(DnFrom));
    termFlag = upHit | dnHit;
  end

  // R2: the control never requests both directions in one cycle
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb));

  // R1: no flag while reset is held
  p_flag_reset_r1: assert property (@(posedge clk)
    rst |-> !termFlag);
endmodule

// File: rtl/updn3_datapath.sv
module updn3_datapath
  import updn3_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  stepStrb_t         strb,
  output logic [CountW-1:0] countVal
);
  localparam int StW = ONE_HOT ? Modulus : CountW;

  logic [StW-1:0] stReg;
  logic [StW-1:0] stNxt;

  generate
    if (ONE_HOT) begin : g_onehot
      localparam logic [StW-1:0] ZeroCode = StW'(1);
      logic legal;
      always_comb begin
        legal = (stReg == 3'b001) || (stReg == 3'b010) || (stReg == 3'b100);
        if (!legal)             stNxt = ZeroCode;
        else if (strb.stepUp)   stNxt = {stReg[1:0], stReg[2]};
        else if (strb.stepDown) stNxt = {stReg[0], stReg[2:1]};
        else                    stNxt = stReg;
        if (stReg[1])      countVal = 2'd1;
        else if (stReg[2]) countVal = 2'd2;
        else               countVal = 2'd0;
      end
      always_ff @(posedge clk) begin
        if (rst) stReg <= ZeroCode;
        else     stReg <= stNxt;
      end
    end else begin : g_binary
      always_comb begin
        unique case (stReg)
          2'd0:    stNxt = strb.stepUp ? 2'd1 : (strb.stepDown ? 2'd2 : 2'd0);
          2'd1:    stNxt = strb.stepUp ? 2'd2 : (strb.stepDown ? 2'd0 : 2'd1);
          2'd2:    stNxt = strb.stepUp ? 2'd0 : (strb.stepDown ? 2'd1 : 2'd2);
          default: stNxt = 2'd0;
        endcase
        countVal = (stReg == 2'd3) ? 2'd0 : stReg;
      end
      always_ff @(posedge clk) begin
        if (rst) stReg <= '0;
        else     stReg <= stNxt;
      end
    end
  endgenerate

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (countVal == 2'd0));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!strb.stepUp && !strb.stepDown) |=> (countVal == $past(countVal)));

  p_up_r3: assert property (@(posedge clk) disable iff (rst)
    strb.stepUp |=> (countVal == (($past(countVal) == 2'd2) ? 2'd0 : $past(countVal) + 2'd1)));

  p_down_r4: assert property (@(posedge clk) disable iff (rst)
    strb.stepDown |=> (countVal == (($past(countVal) == 2'd0) ? 2'd2 : $past(countVal) - 2'd1)));

  p_range_r8: assert property (@(posedge clk) disable iff (rst)
    countVal != 2'd3);
endmodule

// File: rtl/mod3_updown_counter.sv
module mod3_updown_counter
  import updn3_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cntEn,
  input  logic       dirDown,
  output logic [1:0] count,
  output logic       termFlag
);
  stepStrb_t         strb;
  logic [CountW-1:0] countVal;

  updn3_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cntEn    (cntEn),
    .dirDown  (dirDown),
    .countVal (countVal),
    .strb     (strb),
    .termFlag (termFlag)
  );

  updn3_datapath #(.ONE_HOT(ONE_HOT)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .countVal (countVal)
  );

  assign count = countVal;

  p_flag_up_r5: assert property (@(posedge clk) disable iff (rst)
    (termFlag && !dirDown) |=> (count == 2'd2));

  p_flag_dn_r6: assert property (@(posedge clk) disable iff (rst)
    (termFlag && dirDown) |=> (count == 2'd0));
endmodule

// File: tb/mod3_updown_counter_bench.sv
module mod3_updown_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cntEn = 1'b0;
  logic       dirDown = 1'b0;
  logic [1:0] countBin, countOh;
  logic       flagBin, flagOh;

  int nChecks = 0;
  int nFails  = 0;
  int model   = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  mod3_updown_counter #(.ONE_HOT(1'b0)) u_mod3_updown_counter (
    .clk(clk), .rst(rst), .cntEn(cntEn), .dirDown(dirDown),
    .count(countBin), .termFlag(flagBin));

  mod3_updown_counter #(.ONE_HOT(1'b1)) u_mod3_updown_counter_oh (
    .clk(clk), .rst(rst), .cntEn(cntEn), .dirDown(dirDown),
    .count(countOh), .termFlag(flagOh));

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chkBoth(string req, string what, bit isFlag, int exp);
    if (isFlag) begin
      chk(req, {what, " flag (binary)"}, int'(flagBin), exp);
      chk(req, {what, " flag (one-hot)"}, int'(flagOh), exp);
    end else begin
      chk(req, {what, " count (binary)"}, int'(countBin), exp);
      chk(req, {what, " count (one-hot)"}, int'(countOh), exp);
    end
  endtask

  // one clock with the given controls; flag checked before the edge, count after
  task automatic step(bit c, bit d, string req);
    int expFlag;
    int expNext;
    @(negedge clk);
    cntEn = c; dirDown = d;
    #1;
    expFlag = (c && model == 1) ? 1 : 0;
    chkBoth((expFlag != 0) ? (d ? "R6" : "R5") : "R7", req, 1'b1, expFlag);
    if (!c)      expNext = model;
    else if (!d) expNext = (model + 1) % 3;
    else         expNext = (model + 2) % 3;
    @(posedge clk);
    #1;
    chkBoth(req, "after step", 1'b0, expNext);
    model = expNext;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; cntEn = 1'b1; dirDown = 1'b0;
    #1;
    chkBoth("R1", "in reset", 1'b1, 0);
    @(posedge clk);
    #1;
    chkBoth("R1", "after reset", 1'b0, 0);
    chkBoth("R1", "still in reset", 1'b1, 0);
    @(negedge clk);
    rst = 1'b0; cntEn = 1'b0;
    model = 0;
  endtask

  task automatic testHold();
    doReset();
    step(1'b1, 1'b0, "R3");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R2");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R2");
  endtask

  task automatic testUp();
    doReset();
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0, "R3");
  endtask

  task automatic testDown();
    doReset();
    for (int i = 0; i < 7; i++) step(1'b1, 1'b1, "R4");
  endtask

  task automatic testReversal();
    doReset();
    step(1'b1, 1'b0, "R3");
    step(1'b1, 1'b1, "R4");
    step(1'b1, 1'b1, "R4");
    step(1'b0, 1'b1, "R2");
    step(1'b1, 1'b0, "R3");
    step(1'b1, 1'b0, "R3");
  endtask

  // every value x every control combination, for both encodings (R8)
  task automatic testSweep();
    for (int s = 0; s < 3; s++) begin
      for (int cd = 0; cd < 4; cd++) begin
        doReset();
        for (int k = 0; k < s; k++) step(1'b1, 1'b0, "R8");
        step(cd[1], cd[0], "R8");
        chk("R8", "binary and one-hot agree", int'(countBin), int'(countOh));
      end
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    testHold();
    testUp();
    testDown();
    testReversal();
    testSweep();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule